// File: doc/BRIEF.md
# SDRAM Power-Mode and Command Controller

This block turns writes to a control word into SDRAM command-pin activity and power-mode changes. Software brings the memory up by writing an initialization selector, one write per command: precharge-all, mode-register set or NOP. Each write makes the block drive that command for a single clock. Outside those pulses the pins carry NOP. Leaving the selector at "normal" lets ordinary operation continue.

Power management is done through request bits. A self-refresh request is held back while a memory transaction is in flight. Once the bus is quiet, the block issues the self-refresh entry command with CKE low and then raises an acknowledge flag. Software polls this flag to learn the mode that is really in effect. Clearing the request raises CKE and waits out a fixed exit delay before the acknowledge drops. The block starts in self-refresh after reset. Deep power-down is armed only by three bits together, and after it the memory must be re-initialized with a mode-register set before normal operation resumes. A clock-disable bit gates the memory clock output whenever no transaction is in progress.

States: ST_NORMAL (idle, CKE high, issues software commands), ST_SR_WAIT (request pending, bus busy), ST_SR_ENTRY (one-cycle entry command), ST_SELF_REF (CKE low, acknowledged), ST_SR_EXIT (CKE high, exit delay running, still acknowledged), ST_DPD_ENTRY (one-cycle power-down command), ST_DEEP_PD (CKE low, contents lost), ST_REINIT (CKE high, waiting for a mode-register set). Transitions: NORMAL→SR_WAIT on a request while busy; NORMAL or SR_WAIT→SR_ENTRY on a request while idle; SR_WAIT→NORMAL when the request is withdrawn; SR_ENTRY→SELF_REF always; SELF_REF→SR_EXIT when the request clears; SR_EXIT→NORMAL after EXIT_CYC cycles; NORMAL→DPD_ENTRY when power-down is armed and the bus is idle; DPD_ENTRY→DEEP_PD always; DEEP_PD→REINIT when the power-down bit clears; REINIT→NORMAL once a mode-register set has been issued.

Top module: `sdram_pwr_ctl`

## Requirements
- R1: After reset the control word reads 0x0001 (self-refresh request set, all else 0), the acknowledge output `sr_ack` is 1, `cke` is 0 and `clk_out_en` is 1.
- R2: Control bits [5:4] select the initialization command: 00 none, 01 mode-register set, 10 precharge-all, 11 NOP. `mem_cmd` = {cs_n, ras_n, cas_n, we_n} uses the codes NOP 0111, precharge-all 0010, mode-register set 0000, self-refresh entry 0001 and power-down entry 0110.
- R3: A write with a nonzero selector drives its command in the clock after the write for exactly one cycle. Every cycle that carries no other command drives NOP.
- R4: Selector commands are issued only in ST_NORMAL or ST_REINIT, where `cke` is 1. A selector write made in any other state has no effect on the pins.
- R5: When bit 0 (self-refresh request) is 1 and the bus is idle, the self-refresh entry command is driven for one cycle with `cke` low. `sr_ack` rises in the following cycle, and `cke` stays low.
- R6: While `xfer_busy` is 1, a pending self-refresh request issues no entry command and `sr_ack` stays 0. Entry follows once `xfer_busy` is 0.
- R7: Clearing bit 0 in self-refresh raises `cke` one cycle later. `sr_ack` stays 1 for EXIT_CYC cycles with `cke` high, then falls.
- R8: Bit 1 (clock disable) set to 1 drives `clk_out_en` to 0 only while `xfer_busy` is 0. Otherwise `clk_out_en` is 1.
- R9: Power-down entry (command then `cke` low) happens only when bit 6 (deep power-down), bit 2 (clock-enable hold) and bit 3 (free-running clock) are all 1 and the bus is idle. When it is armed, it takes precedence over a self-refresh request.
- R10: Clearing bit 6 in deep power-down raises `cke`. Self-refresh requests and precharge-all commands then leave the block in re-initialization until a mode-register set is issued, after which normal operation (including self-refresh entry) resumes.
- R11: Bits 15:7 are reserved. Writing ones to them has no effect, and they read back as 0.
- R12: When a selector command and a self-refresh request are written together, the selector command is issued first and the self-refresh entry follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | CTRL_W | Control word write data |
| xfer_busy | input | 1 | An SDRAM transaction is in progress |
| mem_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} command pins |
| cke | output | 1 | SDRAM clock enable |
| clk_out_en | output | 1 | Enable for the memory clock output gate |
| sr_ack | output | 1 | Self-refresh acknowledge status |
| reg_rdata | output | CTRL_W | Control word readback |

## Verification
Two functions can collide in one cycle. A selector command and a self-refresh request can be written in the same word, and a deep power-down arm can coincide with a self-refresh request. Both are provoked by single writes carrying both bits, the second while `xfer_busy` is held high. A behavioural model in the bench judges the pin sequence clock by clock. Counters of each issued command confirm the order and that exactly one of each appears.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;

    // control word field positions
    localparam int SRQ_BIT   = 0;
    localparam int CDIS_BIT  = 1;
    localparam int CEH_BIT   = 2;
    localparam int CFREE_BIT = 3;
    localparam int INIT_LSB  = 4;
    localparam int DPD_BIT   = 6;
    localparam int FIELD_TOP = 6;

    typedef enum logic [1:0] {
        INIT_NORMAL = 2'b00,
        INIT_MRS    = 2'b01,
        INIT_PALL   = 2'b10,
        INIT_NOP    = 2'b11
    } init_cmd_e;

    // packed so that bit positions match the control word
    typedef struct packed {
        logic      deep_req;
        init_cmd_e init_sel;
        logic      clk_free;
        logic      cke_hold;
        logic      clk_dis;
        logic      sref_req;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_SR_WAIT,
        ST_SR_ENTRY,
        ST_SELF_REF,
        ST_SR_EXIT,
        ST_DPD_ENTRY,
        ST_DEEP_PD,
        ST_REINIT
    } pwr_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] PIN_NOP  = 4'b0111;
    localparam logic [3:0] PIN_PALL = 4'b0010;
    localparam logic [3:0] PIN_MRS  = 4'b0000;
    localparam logic [3:0] PIN_SREF = 4'b0001;
    localparam logic [3:0] PIN_DPD  = 4'b0110;

endpackage

// File: rtl/sdram_ctl_regs.sv
module sdram_ctl_regs
    import sdram_pwr_pkg::*;
#(
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic              pend_vld,
    output init_cmd_e         pend_cmd,
    output logic [CTRL_W-1:0] rdata
);

    localparam int FIELD_W = FIELD_TOP + 1;
    localparam int RSV_W   = CTRL_W - FIELD_W;

    ctrl_t wr_word;
    logic  unused_rsv_bits;

    assign wr_word         = ctrl_t'(wdata[FIELD_TOP:0]);
    assign unused_rsv_bits = ^wdata[CTRL_W-1:FIELD_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl     <= '{deep_req: 1'b0, init_sel: INIT_NORMAL, clk_free: 1'b0,
                          cke_hold: 1'b0, clk_dis: 1'b0, sref_req: 1'b1};
            pend_vld <= 1'b0;
            pend_cmd <= INIT_NORMAL;
        end else begin
            pend_vld <= wr && (wr_word.init_sel != INIT_NORMAL);
            if (wr) begin
                ctrl     <= wr_word;
                pend_cmd <= wr_word.init_sel;
            end
        end
    end

    assign rdata = {{RSV_W{1'b0}}, ctrl};

endmodule

// File: rtl/sdram_pwr_fsm.sv
module sdram_pwr_fsm
    import sdram_pwr_pkg::*;
#(
    parameter int EXIT_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sref_req,
    input  logic       deep_req,
    input  logic       cke_hold,
    input  logic       clk_free,
    input  logic       pend_vld,
    input  init_cmd_e  pend_cmd,
    input  logic       xfer_busy,
    output logic [3:0] mem_cmd,
    output logic       cke,
    output logic       sr_ack
);

    localparam int CNT_W = $clog2(EXIT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(EXIT_CYC - 1);

    pwr_state_e state, state_nx;
    logic [CNT_W-1:0] exit_cnt;
    logic deep_armed;

    assign deep_armed = deep_req && cke_hold && clk_free;

    // state register and exit-delay counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_SELF_REF;
            exit_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_SELF_REF)
                exit_cnt <= CNT_LOAD;
            else if (state == ST_SR_EXIT && exit_cnt != '0)
                exit_cnt <= exit_cnt - 1'b1;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_NORMAL: begin
                if (pend_vld)
                    state_nx = ST_NORMAL;
                else if (deep_armed)
                    state_nx = xfer_busy ? ST_NORMAL : ST_DPD_ENTRY;
                else if (sref_req)
                    state_nx = xfer_busy ? ST_SR_WAIT : ST_SR_ENTRY;
            end
            ST_SR_WAIT: begin
                if (!sref_req)
                    state_nx = ST_NORMAL;
                else if (!xfer_busy)
                    state_nx = ST_SR_ENTRY;
            end
            ST_SR_ENTRY:  state_nx = ST_SELF_REF;
            ST_SELF_REF:  if (!sref_req) state_nx = ST_SR_EXIT;
            ST_SR_EXIT:   if (exit_cnt == '0) state_nx = ST_NORMAL;
            ST_DPD_ENTRY: state_nx = ST_DEEP_PD;
            ST_DEEP_PD:   if (!deep_req) state_nx = ST_REINIT;
            ST_REINIT:    if (pend_vld && pend_cmd == INIT_MRS) state_nx = ST_NORMAL;
            default:      state_nx = ST_SELF_REF;
        endcase
    end

    // outputs
    always_comb begin
        mem_cmd = PIN_NOP;
        cke     = 1'b1;
        sr_ack  = 1'b0;
        unique case (state)
            ST_NORMAL, ST_REINIT: begin
                if (pend_vld) begin
                    unique case (pend_cmd)
                        INIT_MRS:  mem_cmd = PIN_MRS;
                        INIT_PALL: mem_cmd = PIN_PALL;
                        default:   mem_cmd = PIN_NOP;
                    endcase
                end
            end
            ST_SR_WAIT: ;
            ST_SR_ENTRY: begin
                mem_cmd = PIN_SREF;
                cke     = 1'b0;
            end
            ST_SELF_REF: begin
                cke    = 1'b0;
                sr_ack = 1'b1;
            end
            ST_SR_EXIT:   sr_ack = 1'b1;
            ST_DPD_ENTRY: begin
                mem_cmd = PIN_DPD;
                cke     = 1'b0;
            end
            ST_DEEP_PD:   cke = 1'b0;
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_clk_gate.sv
module sdram_clk_gate (
    input  logic clk_dis,
    input  logic xfer_busy,
    output logic clk_out_en
);

    // a transaction in flight always keeps the clock running
    always_comb begin
        clk_out_en = 1'b1;
        if (clk_dis && !xfer_busy)
            clk_out_en = 1'b0;
    end

endmodule

// File: rtl/sdram_pwr_ctl.sv
module sdram_pwr_ctl
    import sdram_pwr_pkg::*;
#(
    parameter int CTRL_W   = 16,
    parameter int EXIT_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    input  logic              xfer_busy,
    output logic [3:0]        mem_cmd,
    output logic              cke,
    output logic              clk_out_en,
    output logic              sr_ack,
    output logic [CTRL_W-1:0] reg_rdata
);

    ctrl_t     ctrl;
    logic      pend_vld;
    init_cmd_e pend_cmd;

    sdram_ctl_regs #(.CTRL_W(CTRL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .ctrl     (ctrl),
        .pend_vld (pend_vld),
        .pend_cmd (pend_cmd),
        .rdata    (reg_rdata)
    );

    sdram_pwr_fsm #(.EXIT_CYC(EXIT_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sref_req  (ctrl.sref_req),
        .deep_req  (ctrl.deep_req),
        .cke_hold  (ctrl.cke_hold),
        .clk_free  (ctrl.clk_free),
        .pend_vld  (pend_vld),
        .pend_cmd  (pend_cmd),
        .xfer_busy (xfer_busy),
        .mem_cmd   (mem_cmd),
        .cke       (cke),
        .sr_ack    (sr_ack)
    );

    sdram_clk_gate u_gate (
        .clk_dis    (ctrl.clk_dis),
        .xfer_busy  (xfer_busy),
        .clk_out_en (clk_out_en)
    );

endmodule

// File: rtl/sdram_pwr_ctl_chk.sv
module sdram_pwr_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       xfer_busy,
    input logic [3:0] mem_cmd,
    input logic       cke,
    input logic       clk_out_en,
    input logic       sr_ack,
    input logic       deep_arm
);

    localparam logic [3:0] C_PALL = 4'b0010;
    localparam logic [3:0] C_MRS  = 4'b0000;
    localparam logic [3:0] C_SREF = 4'b0001;
    localparam logic [3:0] C_DPD  = 4'b0110;

    p_init_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == C_PALL || mem_cmd == C_MRS) |-> $past(reg_wr));

    p_init_cke_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == C_PALL || mem_cmd == C_MRS) |-> cke);

    p_ack_after_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_ack) |-> $past(mem_cmd == C_SREF && !cke));

    p_entry_idle_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == C_SREF) |-> $past(!xfer_busy));

    p_ack_fall_cke_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_ack) |-> (cke && $past(cke)));

    p_clk_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |-> clk_out_en);

    p_dpd_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == C_DPD) |-> $past(deep_arm && !xfer_busy));

    p_dpd_cke_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == C_DPD) |=> !cke);

endmodule

bind sdram_pwr_ctl sdram_pwr_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .xfer_busy  (xfer_busy),
    .mem_cmd    (mem_cmd),
    .cke        (cke),
    .clk_out_en (clk_out_en),
    .sr_ack     (sr_ack),
    .deep_arm   (reg_rdata[6] & reg_rdata[3] & reg_rdata[2])
);

// File: tb/sdram_pwr_ctl_bench.sv
`timescale 1ns/1ps
module sdram_pwr_ctl_bench;

    localparam int CW   = 16;
    localparam int EXIT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [CW-1:0] reg_wdata = '0;
    logic          xfer_busy = 1'b0;
    logic [3:0]    mem_cmd;
    logic          cke, clk_out_en, sr_ack;
    logic [CW-1:0] reg_rdata;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sdram_pwr_ctl #(.CTRL_W(CW), .EXIT_CYC(EXIT)) u_sdram_pwr_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .xfer_busy(xfer_busy), .mem_cmd(mem_cmd), .cke(cke),
        .clk_out_en(clk_out_en), .sr_ack(sr_ack), .reg_rdata(reg_rdata)
    );

    // behavioural model: 0 normal, 1 wait, 2 sr entry, 3 self-ref,
    // 4 sr exit, 5 dpd entry, 6 deep, 7 reinit
    int         m_mode, m_pend, m_cnt, nm;
    logic [6:0] m_ctrl;
    bit         model_on = 0;
    bit         armed;

    int n_pall = 0, n_mrs = 0, n_sref = 0, n_dpd = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 3; m_ctrl = 7'h01; m_pend = 0; m_cnt = 0; model_on = 1;
        end else begin
            nm    = m_mode;
            armed = m_ctrl[6] && m_ctrl[3] && m_ctrl[2];
            case (m_mode)
                0: if (m_pend == 0) begin
                       if (armed) begin
                           if (!xfer_busy) nm = 5;
                       end else if (m_ctrl[0]) nm = xfer_busy ? 1 : 2;
                   end
                1: if (!m_ctrl[0]) nm = 0; else if (!xfer_busy) nm = 2;
                2: nm = 3;
                3: if (!m_ctrl[0]) begin nm = 4; m_cnt = EXIT; end
                4: begin m_cnt = m_cnt - 1; if (m_cnt == 0) nm = 0; end
                5: nm = 6;
                6: if (!m_ctrl[6]) nm = 7;
                7: if (m_pend == 1) nm = 0;
                default: nm = m_mode;
            endcase
            m_mode = nm;
            m_pend = (reg_wr && reg_wdata[5:4] != 2'b00) ? int'(reg_wdata[5:4]) : 0;
            if (reg_wr) m_ctrl = reg_wdata[6:0];
        end
    end

    function automatic logic [3:0] exp_cmd();
        if (m_mode == 2) return 4'b0001;
        if (m_mode == 5) return 4'b0110;
        if ((m_mode == 0 || m_mode == 7) && m_pend != 0) begin
            if (m_pend == 1) return 4'b0000;
            if (m_pend == 2) return 4'b0010;
        end
        return 4'b0111;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // clock-by-clock comparison, away from the edges
    always @(negedge clk) begin
        #1;
        if (model_on && rst_n) begin
            chk("R2 R3 mem_cmd", mem_cmd, exp_cmd());
            chk("R4 cke", cke, (m_mode == 2 || m_mode == 3 || m_mode == 5 || m_mode == 6) ? 0 : 1);
            chk("R5 sr_ack", sr_ack, (m_mode == 3 || m_mode == 4) ? 1 : 0);
            chk("R8 clk_out_en", clk_out_en, (m_ctrl[1] && !xfer_busy) ? 0 : 1);
            chk("R11 rdata", reg_rdata, {9'b0, m_ctrl});
            if (mem_cmd == 4'b0010) n_pall++;
            if (mem_cmd == 4'b0000) n_mrs++;
            if (mem_cmd == 4'b0001) n_sref++;
            if (mem_cmd == 4'b0110) n_dpd++;
        end
    end

    task automatic wr(input logic [CW-1:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=done");
        finish_run();
    end

    int s_pall, s_mrs, s_sref, s_dpd;

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset rdata", reg_rdata, 16'h0001);
        chk("R1 reset sr_ack", sr_ack, 1);
        chk("R1 reset cke", cke, 0);
        chk("R1 reset clk_out_en", clk_out_en, 1);
        @(negedge clk); rst_n = 1'b1;

        // R7 exit from reset self-refresh
        wr(16'h0000);
        idle(1); #1;
        chk("R7 cke raised", cke, 1);
        chk("R7 ack held during exit", sr_ack, 1);
        idle(EXIT); #1;
        chk("R7 ack dropped after delay", sr_ack, 0);

        // R2/R3 selector commands
        s_pall = n_pall; s_mrs = n_mrs;
        wr(16'h0020); idle(2);
        wr(16'h0030); idle(2);
        wr(16'h0010); idle(2);
        wr(16'h0000); idle(2); #1;
        chk("R3 one precharge-all per write", n_pall - s_pall, 1);
        chk("R2 one mode-register set", n_mrs - s_mrs, 1);

        // R8 clock gating
        wr(16'h0002); #1;
        chk("R8 clock gated when idle", clk_out_en, 0);
        @(negedge clk); xfer_busy = 1'b1; #1;
        chk("R8 clock kept while busy", clk_out_en, 1);
        @(negedge clk); xfer_busy = 1'b0;
        wr(16'h0000);

        // R6 deferral while busy, then R5 entry
        s_sref = n_sref;
        @(negedge clk); xfer_busy = 1'b1;
        wr(16'h0001); idle(5); #1;
        chk("R6 no entry while busy", n_sref - s_sref, 0);
        chk("R6 ack low while busy", sr_ack, 0);
        @(negedge clk); xfer_busy = 1'b0;
        idle(3); #1;
        chk("R5 entry issued", n_sref - s_sref, 1);
        chk("R5 ack set", sr_ack, 1);
        chk("R5 cke low", cke, 0);
        wr(16'h0000); idle(EXIT + 3);

        // R12 selector and request together
        s_pall = n_pall; s_sref = n_sref;
        wr(16'h0021); #1;
        chk("R12 precharge first", mem_cmd, 4'b0010);
        idle(3); #1;
        chk("R12 precharge once", n_pall - s_pall, 1);
        chk("R12 entry follows", n_sref - s_sref, 1);
        wr(16'h0000); idle(EXIT + 3);

        // R11 reserved bits
        wr(16'hFF80); #1;
        chk("R11 reserved read zero", reg_rdata, 16'h0000);
        chk("R11 no mode change", cke, 1);

        // R9 partial arm, busy hold, priority
        s_dpd = n_dpd; s_sref = n_sref;
        wr(16'h0044); idle(4); #1;
        chk("R9 partial arm ignored", n_dpd - s_dpd, 0);
        @(negedge clk); xfer_busy = 1'b1;
        wr(16'h004D); idle(4); #1;
        chk("R9 no entry while busy", n_dpd - s_dpd, 0);
        chk("R9 no self-refresh while armed", n_sref - s_sref, 0);
        @(negedge clk); xfer_busy = 1'b0;
        idle(3); #1;
        chk("R9 power-down entered", n_dpd - s_dpd, 1);
        chk("R9 cke low", cke, 0);
        chk("R9 precedence over self-refresh", n_sref - s_sref, 0);

        // R4 selector ignored in deep power-down
        s_mrs = n_mrs;
        wr(16'h005C); idle(2); #1;
        chk("R4 no command in deep power-down", n_mrs - s_mrs, 0);
        chk("R4 cke stays low", cke, 0);

        // R10 re-initialization
        wr(16'h000C); idle(2); #1;
        chk("R10 cke raised on exit", cke, 1);
        s_pall = n_pall; s_sref = n_sref;
        wr(16'h002C); idle(2);
        wr(16'h000D); idle(4); #1;
        chk("R10 precharge in reinit", n_pall - s_pall, 1);
        chk("R10 request ignored before MRS", n_sref - s_sref, 0);
        chk("R10 ack low before MRS", sr_ack, 0);
        s_mrs = n_mrs;
        wr(16'h001C); idle(2);
        wr(16'h0001); idle(3); #1;
        chk("R10 mode-register set issued", n_mrs - s_mrs, 1);
        chk("R10 normal resumed", n_sref - s_sref, 1);
        chk("R10 ack after resume", sr_ack, 1);

        idle(2);
        finish_run();
    end

endmodule